// File: doc/BRIEF.md
# Deferred Condition Evaluator

This block decides whether a conditional instruction executes, without ever holding a set of arithmetic status flags. Whenever an upstream flag-setting operation completes, the block records a pair of 32-bit operands together with a comparison kind: an arithmetic compare, an exclusive-or test or an and-test. The operation's class selects which pair is recorded. Subtract and compare record the operands as given. Reverse subtract swaps them. Add and compare-negative record one operand negated. Logical operations record their result against zero.

A later instruction presents its 4-bit condition field. The block judges that field against the recorded pair and, one clock later, returns an execute bit. It also returns an undefined-condition trap when the recorded kind cannot answer the requested condition.

The execute decision is registered. It is always based on the state recorded before the cycle in which the request arrives. A capture in the same cycle as a request therefore affects only later requests.

Top module: `defcond_eval`

## Requirements
- R1: After synchronous reset, `res_valid`, `res_exec` and `res_trap` are low, and the recorded state is the compare kind with both operands zero. A first request with condition 0 (equal) therefore executes, and one with condition 1 (not equal) does not.
- R2: A request with `ev_valid` high is answered on the next clock edge with `res_valid` high. When no request was made in the previous cycle, all three outputs are low.
- R3: Condition codes for the compare kind, with recorded pair (x, y): 0 executes when x equals y and 1 when they differ. 2 executes when x >= y unsigned and 3 when x < y unsigned. 8 executes when x > y unsigned and 9 when x <= y unsigned. 10, 11, 12 and 13 execute for signed >=, <, > and <=. 4 executes when bit 31 of x minus y is set, and 5 when it is clear.
- R4: For the exclusive-or kind the result is x XOR y, and for the and-test kind it is x AND y. With that result, code 0 executes when it is zero, code 1 when it is non-zero, code 4 when its bit 31 is set, and code 5 when its bit 31 is clear.
- R5: Code 14 always executes and code 15 never executes, for every kind, and neither raises the trap.
- R6: Codes 6 and 7 raise `res_trap` for every kind. Codes 2, 3 and 8 to 13 raise it for the two test kinds. Whenever the trap is raised, `res_exec` is low.
- R7: `cap_sel` encodes the operation class. 0 (subtract or compare) records (a, b). 1 (reverse subtract) records (b, a). 2 (add) records (b, -a). 3 (compare negative) records (a, -b). 4 (logical) records (res, 0). All five of these select the compare kind.
- R8: `cap_sel` 5 records (a, b) with the exclusive-or kind, and 6 records (a, b) with the and-test kind.
- R9: A capture with `cap_sel` 7 leaves the recorded state unchanged.
- R10: A capture and a request in the same cycle: the request is judged against the state that was recorded before that cycle, and the new state applies from the next request on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cap_valid | input | 1 | Record a new operand pair this cycle |
| cap_sel | input | 3 | Operation class of the flag-setting operation |
| cap_a | input | 32 | First source operand |
| cap_b | input | 32 | Second source operand |
| cap_res | input | 32 | Result of a logical operation |
| ev_valid | input | 1 | Condition request this cycle |
| ev_cond | input | 4 | Condition field of the requesting instruction |
| res_valid | output | 1 | Decision is present |
| res_exec | output | 1 | Instruction executes |
| res_trap | output | 1 | Undefined-condition trap |

## Verification
A capture and a request can land in the same cycle. The two collide over the recorded pair: the request must read the old pair while the capture writes the new one. The bench issues a capture and a request together, with old and new states chosen so that the requested condition has opposite outcomes under the two. It then checks the decision against the old state and checks the following request against the new one. Long random runs mix captures, reserved selects and requests freely, so this overlap also occurs with every kind and every condition.

// File: rtl/dce_pkg.sv
// Shared encodings for the deferred condition evaluator.
// Assumes: the condition field is 4 bits and the operation-class select is 3 bits.
package dce_pkg;

    typedef enum logic [1:0] {
        KIND_CMP = 2'd0,
        KIND_XOR = 2'd1,
        KIND_AND = 2'd2
    } kind_e;

    typedef enum logic [2:0] {
        SEL_SUB   = 3'd0,
        SEL_RSB   = 3'd1,
        SEL_ADD   = 3'd2,
        SEL_CMN   = 3'd3,
        SEL_LOGIC = 3'd4,
        SEL_TEQ   = 3'd5,
        SEL_TST   = 3'd6,
        SEL_NONE  = 3'd7
    } sel_e;

    typedef enum logic [3:0] {
        CC_EQ = 4'd0,  CC_NE = 4'd1,  CC_HS = 4'd2,  CC_LO = 4'd3,
        CC_MI = 4'd4,  CC_PL = 4'd5,  CC_VS = 4'd6,  CC_VC = 4'd7,
        CC_HI = 4'd8,  CC_LS = 4'd9,  CC_GE = 4'd10, CC_LT = 4'd11,
        CC_GT = 4'd12, CC_LE = 4'd13, CC_AL = 4'd14, CC_NV = 4'd15
    } cond_e;

endpackage

// File: rtl/dce_capture.sv
// Operand recorder: forms the saved pair from the operation class and holds it.
// Assumes: negation is two's complement, and select 7 means "no capture".
module dce_capture
    import dce_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_valid,
    input  logic [2:0]        cap_sel,
    input  logic [DATA_W-1:0] cap_a,
    input  logic [DATA_W-1:0] cap_b,
    input  logic [DATA_W-1:0] cap_res,
    output kind_e             st_kind,
    output logic [DATA_W-1:0] st_x,
    output logic [DATA_W-1:0] st_y
);

    sel_e              sel;
    logic              load;
    kind_e             nxt_kind;
    logic [DATA_W-1:0] nxt_x;
    logic [DATA_W-1:0] nxt_y;

    assign sel = sel_e'(cap_sel);

    // Form the pair and kind that the selected operation class records.
    always_comb begin
        load     = cap_valid;
        nxt_kind = KIND_CMP;
        nxt_x    = cap_a;
        nxt_y    = cap_b;
        unique case (sel)
            SEL_SUB:   begin nxt_x = cap_a;   nxt_y = cap_b;           end
            SEL_RSB:   begin nxt_x = cap_b;   nxt_y = cap_a;           end
            SEL_ADD:   begin nxt_x = cap_b;   nxt_y = '0 - cap_a;      end
            SEL_CMN:   begin nxt_x = cap_a;   nxt_y = '0 - cap_b;      end
            SEL_LOGIC: begin nxt_x = cap_res; nxt_y = '0;              end
            SEL_TEQ:   begin nxt_kind = KIND_XOR;                      end
            SEL_TST:   begin nxt_kind = KIND_AND;                      end
            SEL_NONE:  begin load = 1'b0;                              end
            default:   begin load = 1'b0;                              end
        endcase
    end

    // Hold the recorded state; reset to compare kind with zero operands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_kind <= KIND_CMP;
            st_x    <= '0;
            st_y    <= '0;
        end else if (load) begin
            st_kind <= nxt_kind;
            st_x    <= nxt_x;
            st_y    <= nxt_y;
        end
    end

    p_reserved_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_valid && cap_sel == 3'd7) |=> ($stable(st_x) && $stable(st_y) && $stable(st_kind)));

    p_teq_kind_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_valid && cap_sel == 3'd5) |=> (st_kind == KIND_XOR && st_x == $past(cap_a)));

    p_tst_kind_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_valid && cap_sel == 3'd6) |=> (st_kind == KIND_AND && st_y == $past(cap_b)));

    p_logic_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_valid && cap_sel == 3'd4) |=> (st_kind == KIND_CMP && st_y == '0));

    p_rsb_swap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_valid && cap_sel == 3'd1) |=> (st_x == $past(cap_b) && st_y == $past(cap_a)));

endmodule

// File: rtl/dce_cond_eval.sv
// Condition judge: combinational decision of a condition code against a saved pair.
// Assumes: the pair is stable for the cycle; an unsupported code yields trap with no execute.
module dce_cond_eval
    import dce_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  kind_e             kind,
    input  logic [DATA_W-1:0] x,
    input  logic [DATA_W-1:0] y,
    input  logic [3:0]        cond,
    output logic              exec_c,
    output logic              trap_c
);

    localparam int MSB = DATA_W - 1;

    logic [DATA_W-1:0] diff;
    logic [DATA_W-1:0] tres;
    logic              c_eq, c_uge, c_ugt, c_sge, c_sgt, c_neg;
    logic              t_zero, t_neg;
    cond_e             cc;

    assign cc = cond_e'(cond);

    // Relations between the two saved operands for the compare kind.
    always_comb begin
        diff  = x - y;
        c_eq  = (diff == '0);
        c_neg = diff[MSB];
        c_uge = (x >= y);
        c_ugt = (x > y);
        c_sge = ($signed(x) >= $signed(y));
        c_sgt = ($signed(x) > $signed(y));
    end

    // Combined result for the two test kinds.
    always_comb begin
        tres   = (kind == KIND_XOR) ? (x ^ y) : (x & y);
        t_zero = (tres == '0);
        t_neg  = tres[MSB];
    end

    // Map the condition code onto the relations of the current kind.
    always_comb begin
        exec_c = 1'b0;
        trap_c = 1'b0;
        if (cc == CC_AL) begin
            exec_c = 1'b1;
        end else if (cc == CC_NV) begin
            exec_c = 1'b0;
        end else if (kind == KIND_CMP) begin
            unique case (cc)
                CC_EQ:   exec_c = c_eq;
                CC_NE:   exec_c = !c_eq;
                CC_HS:   exec_c = c_uge;
                CC_LO:   exec_c = !c_uge;
                CC_MI:   exec_c = c_neg;
                CC_PL:   exec_c = !c_neg;
                CC_HI:   exec_c = c_ugt;
                CC_LS:   exec_c = !c_ugt;
                CC_GE:   exec_c = c_sge;
                CC_LT:   exec_c = !c_sge;
                CC_GT:   exec_c = c_sgt;
                CC_LE:   exec_c = !c_sgt;
                default: trap_c = 1'b1;
            endcase
        end else if (kind == KIND_XOR || kind == KIND_AND) begin
            unique case (cc)
                CC_EQ:   exec_c = t_zero;
                CC_NE:   exec_c = !t_zero;
                CC_MI:   exec_c = t_neg;
                CC_PL:   exec_c = !t_neg;
                default: trap_c = 1'b1;
            endcase
        end else begin
            trap_c = 1'b1;
        end
    end

endmodule

// File: rtl/defcond_eval.sv
// Deferred condition evaluator top: records operand pairs and answers condition
// requests one cycle later against the state held before the request cycle.
// Assumes: synchronous active-low reset; captures and requests may coincide.
module defcond_eval
    import dce_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int COND_W = 4,
    parameter int SEL_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_valid,
    input  logic [SEL_W-1:0]  cap_sel,
    input  logic [DATA_W-1:0] cap_a,
    input  logic [DATA_W-1:0] cap_b,
    input  logic [DATA_W-1:0] cap_res,
    input  logic              ev_valid,
    input  logic [COND_W-1:0] ev_cond,
    output logic              res_valid,
    output logic              res_exec,
    output logic              res_trap
);

    localparam logic [COND_W-1:0] COND_ALWAYS = COND_W'(14);
    localparam logic [COND_W-1:0] COND_NEVER  = COND_W'(15);

    kind_e             st_kind;
    logic [DATA_W-1:0] st_x;
    logic [DATA_W-1:0] st_y;
    logic              exec_c;
    logic              trap_c;

    dce_capture #(.DATA_W(DATA_W)) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_valid (cap_valid),
        .cap_sel   (cap_sel),
        .cap_a     (cap_a),
        .cap_b     (cap_b),
        .cap_res   (cap_res),
        .st_kind   (st_kind),
        .st_x      (st_x),
        .st_y      (st_y)
    );

    dce_cond_eval #(.DATA_W(DATA_W)) u_eval (
        .kind   (st_kind),
        .x      (st_x),
        .y      (st_y),
        .cond   (ev_cond),
        .exec_c (exec_c),
        .trap_c (trap_c)
    );

    // Register the decision; outputs stay low when no request was made.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_exec  <= 1'b0;
            res_trap  <= 1'b0;
        end else begin
            res_valid <= ev_valid;
            res_exec  <= ev_valid && exec_c;
            res_trap  <= ev_valid && trap_c;
        end
    end

    p_trap_no_exec_r6: assert property (@(posedge clk) disable iff (!rst_n)
        res_trap |-> !res_exec);

    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> (!res_exec && !res_trap));

    p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(ev_valid)) |-> res_valid);

    p_always_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(ev_valid) && $past(ev_cond) == COND_ALWAYS) |-> (res_exec && !res_trap));

    p_never_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(ev_valid) && $past(ev_cond) == COND_NEVER) |-> (!res_exec && !res_trap));

    p_overflow_codes_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(ev_valid) && ($past(ev_cond) == COND_W'(6) || $past(ev_cond) == COND_W'(7)))
        |-> res_trap);

endmodule

// File: tb/defcond_eval_tb.sv
`timescale 1ns/1ps
module defcond_eval_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cap_valid = 1'b0;
    logic [2:0]  cap_sel = 3'd0;
    logic [31:0] cap_a = '0, cap_b = '0, cap_res = '0;
    logic        ev_valid = 1'b0;
    logic [3:0]  ev_cond = 4'd0;
    logic        res_valid, res_exec, res_trap;

    integer n_vec = 0;
    integer n_bad = 0;

    // Reference state: kind 0 compare, 1 xor, 2 and.
    logic [31:0] mx = '0, my = '0;
    int          mk = 0;

    always #2.5 clk = ~clk;

    defcond_eval u_dut (
        .clk(clk), .rst_n(rst_n), .cap_valid(cap_valid), .cap_sel(cap_sel),
        .cap_a(cap_a), .cap_b(cap_b), .cap_res(cap_res),
        .ev_valid(ev_valid), .ev_cond(ev_cond),
        .res_valid(res_valid), .res_exec(res_exec), .res_trap(res_trap)
    );

    function automatic void model_eval(input int k, input logic [31:0] x, input logic [31:0] y,
                                       input int c, output bit ex, output bit tr);
        longint ux = longint'({32'h0, x});
        longint uy = longint'({32'h0, y});
        longint sx = longint'($signed(x));
        longint sy = longint'($signed(y));
        logic [31:0] d = x - y;
        logic [31:0] t = (k == 1) ? (x ^ y) : (x & y);
        ex = 0; tr = 0;
        if (c == 14) ex = 1;
        else if (c == 15) ex = 0;
        else if (k == 0) begin
            case (c)
                0: ex = (ux == uy);   1: ex = (ux != uy);
                2: ex = (ux >= uy);   3: ex = (ux < uy);
                4: ex = d[31];        5: ex = !d[31];
                8: ex = (ux > uy);    9: ex = (ux <= uy);
                10: ex = (sx >= sy);  11: ex = (sx < sy);
                12: ex = (sx > sy);   13: ex = (sx <= sy);
                default: tr = 1;
            endcase
        end else begin
            case (c)
                0: ex = (t == 0);  1: ex = (t != 0);
                4: ex = t[31];     5: ex = !t[31];
                default: tr = 1;
            endcase
        end
    endfunction

    function automatic string tag_for(input int k, input int c);
        if (c >= 14) return "R5";
        if (c == 6 || c == 7) return "R6";
        if (k != 0 && !(c == 0 || c == 1 || c == 4 || c == 5)) return "R6";
        return (k == 0) ? "R3" : "R4";
    endfunction

    // One cycle: drive after the falling edge, check after the next rising edge.
    task automatic step(input bit cv, input logic [2:0] sel, input logic [31:0] a,
                        input logic [31:0] b, input logic [31:0] r,
                        input bit ev, input logic [3:0] c, input string tag);
        bit ex, tr;
        string t;
        cap_valid = cv; cap_sel = sel; cap_a = a; cap_b = b; cap_res = r;
        ev_valid = ev; ev_cond = c;
        ex = 0; tr = 0;
        if (ev) model_eval(mk, mx, my, int'(c), ex, tr);
        t = (tag == "") ? tag_for(mk, int'(c)) : tag;
        if (cv) begin
            case (sel)
                3'd0: begin mx = a;   my = b;      mk = 0; end
                3'd1: begin mx = b;   my = a;      mk = 0; end
                3'd2: begin mx = b;   my = 0 - a;  mk = 0; end
                3'd3: begin mx = a;   my = 0 - b;  mk = 0; end
                3'd4: begin mx = r;   my = 0;      mk = 0; end
                3'd5: begin mx = a;   my = b;      mk = 1; end
                3'd6: begin mx = a;   my = b;      mk = 2; end
                default: ;
            endcase
        end
        @(posedge clk); #1;
        n_vec++;
        if (res_valid !== ev || res_exec !== ex || res_trap !== tr) begin
            n_bad++;
            $display("FAIL %s cond=%0d: actual valid/exec/trap=%b%b%b expected=%b%b%b",
                     t, c, res_valid, res_exec, res_trap, ev, ex, tr);
        end
        @(negedge clk);
    endtask

    task automatic sweep(input string tag);
        for (int c = 0; c < 16; c++) step(0, 3'd0, 0, 0, 0, 1, 4'(c), tag);
    endtask

    initial begin
        #(5.0 * 150000);
        n_bad++;
        $display("FAIL R2 watchdog: actual hung run, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        n_vec++;
        if (res_valid !== 0 || res_exec !== 0 || res_trap !== 0) begin
            n_bad++;
            $display("FAIL R1 reset outputs: actual %b%b%b expected 000", res_valid, res_exec, res_trap);
        end
        @(negedge clk); rst_n = 1'b1;
        // R1: initial state compares zero with zero.
        step(0, 0, 0, 0, 0, 1, 4'd0, "R1");
        step(0, 0, 0, 0, 0, 1, 4'd1, "R1");
        // R2: idle cycle is quiet.
        step(0, 0, 0, 0, 0, 0, 4'd14, "R2");
        // R7: each operand-forming class.
        step(1, 3'd0, 5, 5, 0, 0, 0, "R7");          step(0, 0, 0, 0, 0, 1, 4'd0, "R7");
        step(1, 3'd1, 3, 7, 0, 0, 0, "R7");          step(0, 0, 0, 0, 0, 1, 4'd8, "R7");
        step(1, 3'd2, 1, 32'hFFFF_FFFF, 0, 0, 0, "R7"); step(0, 0, 0, 0, 0, 1, 4'd0, "R7");
        step(1, 3'd3, 4, 32'hFFFF_FFFC, 0, 0, 0, "R7"); step(0, 0, 0, 0, 0, 1, 4'd0, "R7");
        step(1, 3'd4, 9, 9, 32'h8000_0000, 0, 0, "R7"); step(0, 0, 0, 0, 0, 1, 4'd4, "R7");
        // R3: full sweeps over sign and magnitude corners.
        step(1, 3'd0, 32'hFFFF_FFFF, 1, 0, 0, 0, "R3"); sweep("");
        step(1, 3'd0, 1, 32'hFFFF_FFFF, 0, 0, 0, "R3"); sweep("");
        step(1, 3'd0, 32'h8000_0000, 1, 0, 0, 0, "R3"); sweep("");
        step(1, 3'd0, 7, 7, 0, 0, 0, "R3");             sweep("");
        // R8/R4: test kinds.
        step(1, 3'd5, 32'hA5A5_0000, 32'hA5A5_0000, 0, 0, 0, "R8"); step(0, 0, 0, 0, 0, 1, 4'd0, "R8");
        sweep("");
        step(1, 3'd5, 32'h0000_0001, 32'h8000_0001, 0, 0, 0, "R8"); sweep("");
        step(1, 3'd6, 32'h0000_00F0, 32'h0000_000F, 0, 0, 0, "R8"); step(0, 0, 0, 0, 0, 1, 4'd0, "R8");
        sweep("");
        step(1, 3'd6, 32'hC000_0000, 32'h8000_0000, 0, 0, 0, "R8"); sweep("");
        // R6: overflow codes under compare kind.
        step(1, 3'd0, 1, 2, 0, 0, 0, "R6");
        step(0, 0, 0, 0, 0, 1, 4'd6, "R6"); step(0, 0, 0, 0, 0, 1, 4'd7, "R6");
        // R9: reserved select leaves (5, 9) in place.
        step(1, 3'd0, 5, 9, 0, 0, 0, "R9");
        step(1, 3'd7, 0, 0, 0, 0, 0, "R9");
        step(0, 0, 0, 0, 0, 1, 4'd3, "R9");
        step(0, 0, 0, 0, 0, 1, 4'd1, "R9");
        // R10: capture and request together use the old pair.
        step(1, 3'd0, 2, 2, 0, 1, 4'd0, "R10");
        step(0, 0, 0, 0, 0, 1, 4'd0, "R10");
        step(1, 3'd5, 3, 3, 0, 1, 4'd11, "R10");
        step(0, 0, 0, 0, 0, 1, 4'd11, "R10");
        // Random mix.
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] pool [5];
            logic [31:0] a, b;
            pool[0] = 0; pool[1] = 1; pool[2] = 32'h8000_0000;
            pool[3] = 32'hFFFF_FFFF; pool[4] = 32'h7FFF_FFFF;
            a = ($urandom_range(0, 2) == 0) ? pool[$urandom_range(0, 4)] : $urandom;
            b = ($urandom_range(0, 3) == 0) ? a : (($urandom_range(0, 2) == 0) ? pool[$urandom_range(0, 4)] : $urandom);
            step(1'($urandom_range(0, 1)), 3'($urandom_range(0, 7)), a, b, $urandom,
                 1'($urandom_range(0, 3) != 0), 4'($urandom_range(0, 15)), "");
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule